// File: doc/BRIEF.md
# USB device interrupt status aggregator

This block gathers event conditions from the endpoint control-status logic of a full-speed USB device controller. It exposes them to a CPU as two 8-bit status registers. Each status bit is cleared by writing a one to it. The covered sources are endpoint 0, three IN/OUT endpoint pairs, a shared overrun/underrun condition, host bus reset, suspend and resume. A single interrupt request line is the OR of every status bit.

The endpoint inputs are the live levels of the control-status bits. The block detects the transitions that matter on each of them. Some bits raise an event when they become set, and others when hardware clears them. The block also contains the idle timer that declares suspend. It holds the suspended state, which ends on the first non-idle line state.

The register port is a plain select/write port, and the read data is registered. `reg_sel` 0 selects status register 1 and 1 selects status register 2. `rd_data` shows the selected register as it stood one clock earlier.

Top module: `usb_irq_status`

## Requirements
- R1: Writing with `wr_en` high clears every bit of the selected register whose `wr_data` bit is 1. Bits written with 0 keep their value. The reset value of both registers is 0x00.
- R2: Register 1 has the following layout, and its bit 1 always reads 0:
  - bit 0: endpoint 0
  - bits 2, 4, 6: IN endpoints 1, 2, 3
  - bits 3, 5, 7: OUT endpoints 1, 2, 3

  Register 2 bits 0 to 3 always read 0.
- R3: The endpoint 0 bit is set by any of these transitions:
  - a 0-to-1 change of `ep0_out_rdy`, `ep0_force_stall` or `ep0_setup_end`
  - a 1-to-0 change of `ep0_in_rdy` or `ep0_data_end`

  The opposite transition of each of these inputs has no effect.
- R4: The bit of IN endpoint n (n = 1..3, input index n-1) is set by a 1-to-0 change of `in_pkt_rdy[n-1]` or a 0-to-1 change of `in_underrun[n-1]`.
- R5: The bit of OUT endpoint n is set by a 0-to-1 change of any of `out_pkt_rdy[n-1]`, `out_overrun[n-1]` or `out_force_stall[n-1]`.
- R6: Register 2 bit 4 is set by a 0-to-1 change of any `in_underrun` or `out_overrun` bit.
- R7: A cycle with `bus_reset` high has the following effect:
  - it sets register 2 bit 5
  - it clears every other status bit
  - it ends the suspended state and restarts the idle timer
  - it discards events that arrive in the same cycle

  Register 2 bit 5 stays set through further bus resets.
- R8: Register 2 bit 7 is set on the (IDLE_LIMIT+1)-th consecutive clock with `line_idle` high, and the block then enters the suspended state. The bit is set at most once per idle period, and a non-idle cycle starts a new period.
- R9: Register 2 bit 6 is set by a clock with `line_idle` low while the block is suspended, and that clock ends the suspended state. Non-idle clocks while not suspended do not set the bit.
- R10: `irq` is high exactly one clock after any status bit is 1, and low one clock after all status bits are 0.
- R11: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R12: `rd_data` equals the register selected by `reg_sel` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep0_out_rdy | input | 1 | Endpoint 0 OUT packet-ready level |
| ep0_in_rdy | input | 1 | Endpoint 0 IN packet-ready level |
| ep0_data_end | input | 1 | Endpoint 0 data-end level |
| ep0_force_stall | input | 1 | Endpoint 0 stall level |
| ep0_setup_end | input | 1 | Endpoint 0 setup-end level |
| in_pkt_rdy | input | 3 | IN endpoint 1..3 packet-ready levels |
| in_underrun | input | 3 | IN endpoint 1..3 underrun levels |
| out_pkt_rdy | input | 3 | OUT endpoint 1..3 packet-ready levels |
| out_overrun | input | 3 | OUT endpoint 1..3 overrun levels |
| out_force_stall | input | 3 | OUT endpoint 1..3 stall levels |
| bus_reset | input | 1 | Host reset signalling detected |
| line_idle | input | 1 | High while D+/D- are in the idle state |
| reg_sel | input | 1 | Register select: 0 = status 1, 1 = status 2 |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 8 | Clear mask |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives each endpoint input in both directions. A block that detected the wrong edge would set a flag on a hardware set of IN packet-ready, or miss a data-end clear. The idle timer is probed on the cycle before and the cycle of its threshold. An off-by-one counter would flag suspend a cycle early or late, and a timer that re-armed would flag suspend twice in one idle period. Further corner cases are:
- a write-one-to-clear that coincides with an event, where a clear-wins design loses the flag
- a bus reset that coincides with the end of suspend, where a block that kept the suspended state would report a spurious resume
- a bus reset repeated on a set bus-reset flag, which must keep the flag set

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NUM_EP   = 3;
  localparam int REG_W    = 8;
  localparam int EP0_SRC  = 5;
  // register 2 bit positions
  localparam int R2_XRUN  = 4;
  localparam int R2_BRST  = 5;
  localparam int R2_RSM   = 6;
  localparam int R2_SUSP  = 7;
  localparam logic [REG_W-1:0] R1_VALID = 8'hFD;
  localparam logic [REG_W-1:0] R2_VALID = 8'hF0;
endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge #(
  parameter int W = 8,
  parameter logic [W-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] evt
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign evt[i] = hist_q[i] & ~d[i];
    end else begin : g_rise
      assign evt[i] = d[i] & ~hist_q[i];
    end
  end
endmodule

// File: rtl/usb_irq_idle_timer.sv
module usb_irq_idle_timer #(
  parameter int IDLE_LIMIT = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic line_idle,
  output logic fire,
  output logic wake,
  output logic suspended
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          susp_q;

  assign fire      = line_idle && !done_q && (cnt_q == LIM);
  assign wake      = susp_q && !line_idle;
  assign suspended = susp_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
    end else if (!line_idle) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LIM) begin
        done_q <= 1'b1;
        susp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int IDLE_LIMIT = 144000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic              ep0_data_end,
  input  logic              ep0_force_stall,
  input  logic              ep0_setup_end,
  input  logic [NUM_EP-1:0] in_pkt_rdy,
  input  logic [NUM_EP-1:0] in_underrun,
  input  logic [NUM_EP-1:0] out_pkt_rdy,
  input  logic [NUM_EP-1:0] out_overrun,
  input  logic [NUM_EP-1:0] out_force_stall,
  input  logic              bus_reset,
  input  logic              line_idle,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam int SW     = EP0_SRC + 5 * NUM_EP;
  localparam int O_IRDY = EP0_SRC;
  localparam int O_IUR  = O_IRDY + NUM_EP;
  localparam int O_ORDY = O_IUR + NUM_EP;
  localparam int O_OOV  = O_ORDY + NUM_EP;
  localparam int O_OST  = O_OOV + NUM_EP;
  // endpoint 0 in-ready and data-end, and every IN packet-ready, act on clearing
  localparam logic [SW-1:0] FALL_MASK =
    {{(4*NUM_EP){1'b0}}, {NUM_EP{1'b1}}, 5'b00110};

  logic [SW-1:0]    src, evt;
  logic             ep0_evt, xrun_evt;
  logic [NUM_EP-1:0] in_evt, out_evt;
  logic [REG_W-1:0] set1, set2, clr1, clr2;
  logic [REG_W-1:0] flag1_q, flag2_q;
  logic             susp_fire, wake_evt, suspended;

  assign src = {out_force_stall, out_overrun, out_pkt_rdy, in_underrun, in_pkt_rdy,
                ep0_setup_end, ep0_force_stall, ep0_data_end, ep0_in_rdy, ep0_out_rdy};

  usb_irq_edge #(.W(SW), .FALL_MASK(FALL_MASK)) i_edge (
    .clk(clk), .rst(rst), .d(src), .evt(evt)
  );

  usb_irq_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) i_timer (
    .clk(clk), .rst(rst), .restart(bus_reset), .line_idle(line_idle),
    .fire(susp_fire), .wake(wake_evt), .suspended(suspended)
  );

  assign ep0_evt = |evt[EP0_SRC-1:0];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign in_evt[e]  = evt[O_IRDY+e] | evt[O_IUR+e];
    assign out_evt[e] = evt[O_ORDY+e] | evt[O_OOV+e] | evt[O_OST+e];
  end

  assign xrun_evt = (|evt[O_IUR +: NUM_EP]) | (|evt[O_OOV +: NUM_EP]);

  always_comb begin
    set1    = '0;
    set1[0] = ep0_evt;
    for (int e = 0; e < NUM_EP; e++) begin
      set1[2 + 2*e] = in_evt[e];
      set1[3 + 2*e] = out_evt[e];
    end
    set2           = '0;
    set2[R2_XRUN]  = xrun_evt;
    set2[R2_RSM]   = wake_evt;
    set2[R2_SUSP]  = susp_fire;
    clr1 = (wr_en && !reg_sel) ? wr_data : '0;
    clr2 = (wr_en &&  reg_sel) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag1_q <= '0;
      flag2_q <= '0;
    end else if (bus_reset) begin
      flag1_q          <= '0;
      flag2_q          <= '0;
      flag2_q[R2_BRST] <= 1'b1;
    end else begin
      flag1_q <= ((flag1_q & ~clr1) | set1) & R1_VALID;
      flag2_q <= ((flag2_q & ~clr2) | set2) & R2_VALID;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= reg_sel ? flag2_q : flag1_q;
      irq     <= |{flag1_q, flag2_q};
    end
  end
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_reset,
  input logic       line_idle,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic [7:0] flag1,
  input logic [7:0] flag2,
  input logic       ep0_evt,
  input logic       susp_fire,
  input logic       suspended
);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ep0_evt && !bus_reset) |=> flag1[0]);

  a_r1_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !reg_sel && !wr_data[0] && flag1[0] && !bus_reset) |=> flag1[0]);

  a_r2_reserved1: assert property (@(posedge clk) disable iff (rst)
    !reg_sel |=> !rd_data[1]);

  a_r2_low_nibble: assert property (@(posedge clk) disable iff (rst)
    reg_sel |=> (rd_data[3:0] == 4'h0));

  a_r7_bus_reset: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (flag1 == 8'h00 && flag2 == 8'h20));

  a_r9_resume: assert property (@(posedge clk) disable iff (rst)
    (suspended && !line_idle && !bus_reset) |=> (!suspended && flag2[6]));

  a_r8_fire_idle: assert property (@(posedge clk) disable iff (rst)
    susp_fire |-> line_idle);

  a_r8_fire_once: assert property (@(posedge clk) disable iff (rst)
    susp_fire |=> !susp_fire);

  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    (flag1 == 8'h00 && flag2 == 8'h00) |=> !irq);

  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    (flag1 != 8'h00) |=> irq);
endmodule

bind usb_irq_status usb_irq_status_chk i_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .line_idle(line_idle),
  .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .irq(irq), .flag1(flag1_q), .flag2(flag2_q), .ep0_evt(ep0_evt),
  .susp_fire(susp_fire), .suspended(suspended)
);

// File: tb/test_usb_irq_status.sv
`timescale 1ns/1ps
module test_usb_irq_status;
  localparam int LIM = 20;
  localparam int NV  = 16;
  // {pre[19:0], post[19:0], expected reg1, expected reg2}
  // source bits: [0] ep0 out_rdy [1] ep0 in_rdy [2] data_end [3] stall [4] setup_end
  // [7:5] in_pkt_rdy [10:8] in_underrun [13:11] out_pkt_rdy [16:14] overrun [19:17] out stall
  localparam logic [55:0] VEC [NV] = '{
    56'h00000_00001_01_00, // R3 out_rdy rise
    56'h00001_00000_00_00, // R3 out_rdy fall ignored
    56'h00002_00000_01_00, // R3 in_rdy clear
    56'h00000_00002_00_00, // R3 in_rdy set ignored
    56'h00004_00000_01_00, // R3 data_end clear
    56'h00000_00008_01_00, // R3 stall set
    56'h00000_00010_01_00, // R3 setup_end set
    56'h00010_00000_00_00, // R3 setup_end clear ignored
    56'h00020_00000_04_00, // R4 ep1 in_rdy clear
    56'h00000_00200_10_10, // R4 R6 ep2 underrun
    56'h00000_02000_80_00, // R5 ep3 out_rdy
    56'h00000_04000_08_10, // R5 R6 ep1 overrun
    56'h00000_40000_20_00, // R5 ep2 out stall
    56'h00000_00080_00_00, // R4 ep3 in_rdy set ignored
    56'h00080_01000_60_00, // R4 R5 two endpoints
    56'h00100_00000_00_00  // R6 underrun fall ignored
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ep0_out_rdy = 0, ep0_in_rdy = 0, ep0_data_end = 0, ep0_force_stall = 0, ep0_setup_end = 0;
  logic [2:0] in_pkt_rdy = 0, in_underrun = 0, out_pkt_rdy = 0, out_overrun = 0, out_force_stall = 0;
  logic bus_reset = 0, line_idle = 0, reg_sel = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, failures = 0;
  logic [7:0] val;

  always #2.5 clk = ~clk;

  usb_irq_status #(.IDLE_LIMIT(LIM)) i_usb_irq_status (
    .clk(clk), .rst(rst),
    .ep0_out_rdy(ep0_out_rdy), .ep0_in_rdy(ep0_in_rdy), .ep0_data_end(ep0_data_end),
    .ep0_force_stall(ep0_force_stall), .ep0_setup_end(ep0_setup_end),
    .in_pkt_rdy(in_pkt_rdy), .in_underrun(in_underrun), .out_pkt_rdy(out_pkt_rdy),
    .out_overrun(out_overrun), .out_force_stall(out_force_stall),
    .bus_reset(bus_reset), .line_idle(line_idle), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [19:0] v);
    {ep0_setup_end, ep0_force_stall, ep0_data_end, ep0_in_rdy, ep0_out_rdy} = v[4:0];
    in_pkt_rdy = v[7:5];      in_underrun = v[10:8];
    out_pkt_rdy = v[13:11];   out_overrun = v[16:14];
    out_force_stall = v[19:17];
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel;
    @(posedge clk); @(negedge clk); d = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    // R1 R12 reset values
    rd(1'b0, val); check("R1 reset reg1", val, 8'h00);
    rd(1'b1, val); check("R1 reset reg2", val, 8'h00);
    check("R10 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); apply(VEC[i][55:36]);
      repeat (3) @(posedge clk);
      wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
      apply(VEC[i][35:16]);
      rd(1'b0, val); check($sformatf("R3-5 vec%0d reg1", i), val, VEC[i][15:8]);
      rd(1'b1, val); check($sformatf("R6 vec%0d reg2", i), val, VEC[i][7:0]);
    end

    // R1 R2 R10 write-one-to-clear
    @(negedge clk); apply(20'h00020);
    repeat (3) @(posedge clk);
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
    apply(20'h00001);
    rd(1'b0, val); check("R3 R4 two flags", val, 8'h05);
    check("R10 irq set", {7'b0, irq}, 8'h01);
    wr(1'b0, 8'h00); rd(1'b0, val); check("R1 zero write", val, 8'h05);
    wr(1'b0, 8'h01); rd(1'b0, val); check("R1 clear bit0", val, 8'h04);
    wr(1'b0, 8'h02); rd(1'b0, val); check("R2 reserved bit", val, 8'h04);
    wr(1'b0, 8'h04); rd(1'b0, val); check("R1 all clear", val, 8'h00);
    check("R10 irq clear", {7'b0, irq}, 8'h00);

    // R11 set beats clear
    @(negedge clk); apply(20'h00000);
    repeat (2) @(posedge clk);
    @(negedge clk); ep0_out_rdy = 1'b1; reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    rd(1'b0, val); check("R11 set wins", val, 8'h01);
    wr(1'b0, 8'hFF);
    @(negedge clk); apply(20'h00000);

    // R8 suspend threshold
    rd(1'b1, val); check("R8 pre suspend", val, 8'h00);
    @(negedge clk); line_idle = 1'b1;
    repeat (LIM + 1) @(posedge clk);
    @(negedge clk); check("R8 one cycle early", rd_data, 8'h00);
    @(posedge clk); @(negedge clk); check("R8 suspend set", rd_data, 8'h80);
    wr(1'b1, 8'h80);
    repeat (3 * LIM) @(posedge clk);
    rd(1'b1, val); check("R8 once per period", val, 8'h00);
    // R9 resume
    @(negedge clk); line_idle = 1'b0;
    rd(1'b1, val); check("R9 resume set", val, 8'h40);
    wr(1'b1, 8'h40);
    @(negedge clk); line_idle = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); line_idle = 1'b0;
    repeat (3) @(posedge clk);
    rd(1'b1, val); check("R9 no resume unsuspended", val, 8'h00);

    // R7 bus reset
    @(negedge clk); apply(20'h00201);
    repeat (2) @(posedge clk);
    rd(1'b1, val); check("R6 before bus reset", val, 8'h10);
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    rd(1'b0, val); check("R7 reg1 cleared", val, 8'h00);
    rd(1'b1, val); check("R7 reset flag", val, 8'h20);
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    rd(1'b1, val); check("R7 flag survives", val, 8'h20);
    wr(1'b1, 8'h20); rd(1'b1, val); check("R7 flag cleared by write", val, 8'h00);
    // R7 bus reset ends suspended state
    @(negedge clk); line_idle = 1'b1;
    repeat (LIM + 4) @(posedge clk);
    wr(1'b1, 8'h80);
    @(negedge clk); bus_reset = 1'b1; line_idle = 1'b0;
    @(negedge clk); bus_reset = 1'b0;
    repeat (3) @(posedge clk);
    rd(1'b1, val); check("R7 R9 no resume after bus reset", val, 8'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule